// File: doc/BRIEF.md
# Interlocked Peripheral Controller Interface

This block is the shared logic that sits between a host I/O bus and the device-specific work area of a peripheral controller. It turns the bus's active-low command and data cycles into single-cycle strobes for the work area. It holds a parameterised set of interrupt request channels, two by default, and one direct-memory request channel. It also guards the device with an interlock. While the work area reports that it is busy, a new command produces no register load. The refused attempt is instead recorded in a sticky flag, which the host can read and which clears on the read.

All bus-side controls are active-low, with one exception. The initial-condition input is active-high, so a host that stops driving the bus leaves the controller normalized. This input passes through a two-stage synchronizer and then acts as a synchronous reset for every flag and enable. It is also passed to the work area, so that the device can return to its idle state. The block is clocked by the free-running bus clock. All bus inputs are assumed to be synchronous to that clock.

Top module: `pcif_ctrl`

## Requirements
- R1: A high-to-low transition of `cmd_stb_n` seen while `dev_busy` is 0 produces exactly one `cmd_load` pulse, one clock after the edge. Holding `cmd_stb_n` low produces no further pulse.
- R2: A high-to-low transition of `cmd_stb_n` seen while `dev_busy` is 1 produces no `cmd_load`, and sets `reject_flag` one clock later.
- R3: `reject_flag` stays set until a high-to-low transition of `stat_rd_n`, which clears it one clock later. A new refusal in the same cycle keeps it set.
- R4: Every high-to-low transition of `wdata_stb_n` gives exactly one single-cycle `wdata_pulse`, one clock later, whatever the state of `dev_busy`.
- R5: Each interrupt channel has a sticky request. A high level on `irq_event[i]` sets it and a low level on `irq_ack_n[i]` clears it. When both occur in the same cycle, the set wins.
- R6: `irq_req_n[i]` is 0 exactly when channel i's request is set and its enable bit is 1. The enable bits load from `irq_en_val` on every clock in which `irq_en_wr_n` is 0, with bit i belonging to channel i.
- R7: With `dma_want` at 1, `dma_req_n` goes to 0 and stays there until a clock with `dma_ack_n` at 0. After that clock it reads 1 for at least two samples before it can reassert.
- R8: `norm_out` follows `init_cond` two clocks later. One clock after `norm_out` rises, all interrupt requests, enables, the DMA request and `reject_flag` are cleared. This makes `irq_req_n` all ones and `dma_req_n` equal to 1.
- R9: While `norm_out` is 1, strobe edges produce no `cmd_load` or `wdata_pulse`. Enables stay cleared after normalization ends, so a later interrupt event does not drive `irq_req_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock |
| init_cond | input | 1 | Initial-condition request, active high, asynchronous |
| cmd_stb_n | input | 1 | Bus command cycle, active low |
| wdata_stb_n | input | 1 | Bus output-data cycle, active low |
| stat_rd_n | input | 1 | Bus status read cycle, active low |
| dev_busy | input | 1 | Work area performing a command |
| cmd_load | output | 1 | Command register load strobe to work area |
| wdata_pulse | output | 1 | Output-data strobe to work area |
| reject_flag | output | 1 | Sticky: command refused by interlock |
| norm_out | output | 1 | Synchronized normalize to work area |
| irq_event | input | N_IRQ | Interrupt event per channel from work area |
| irq_ack_n | input | N_IRQ | Interrupt acknowledge per channel, active low |
| irq_en_wr_n | input | 1 | Enable-register write, active low |
| irq_en_val | input | N_IRQ | Enable bits to write |
| irq_req_n | output | N_IRQ | Interrupt request per channel to bus, active low |
| dma_want | input | 1 | Work area wants a DMA transfer |
| dma_ack_n | input | 1 | DMA grant from bus, active low |
| dma_req_n | output | 1 | DMA request to bus, active low |

## Verification
Several properties are checked on every cycle. A load or data strobe never lasts two cycles, and a load never follows a busy sample. The reject flag only rises after a busy sample. An interrupt request only falls after an acknowledge, and the DMA request never drops without a grant. After a grant, the DMA request stays off for the following cycle, and normalization clears all flags one cycle after it rises. Other behaviour can only be shown by the bench's scenarios. These are the exact latencies, a single pulse for a strobe held low, set-over-acknowledge priority, read-to-clear of the reject flag, the two-clock synchronizer delay, and enables that stay cleared after normalization ends.

// File: rtl/pcif_pkg.sv
package pcif_pkg;
  // High-to-low transition of an active-low strobe.
  function automatic logic fall_of(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // Sticky bit: a set takes priority over a clear.
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/pcif_sync.sv
module pcif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d};

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pcif_edge.sv
module pcif_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic [W-1:0] stb_n,
  output logic [W-1:0] fall
);
  import pcif_pkg::*;

  // The previous level is tracked even during normalize, so a strobe held
  // low across the end of normalization does not produce a false edge.
  logic [W-1:0] prev_n;

  always_ff @(posedge clk) prev_n <= stb_n;

  for (genvar i = 0; i < W; i++) begin : g_fall
    assign fall[i] = fall_of(prev_n[i], stb_n[i]);
  end
endmodule

// File: rtl/pcif_irq_chan.sv
module pcif_irq_chan (
  input  logic clk,
  input  logic norm,
  input  logic event_i,
  input  logic ack_n,
  input  logic en_wr,
  input  logic en_val,
  output logic req_n
);
  import pcif_pkg::*;

  logic pend_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (norm) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= sticky_next(pend_q, event_i, ~ack_n);
      if (en_wr) en_q <= en_val;
    end
  end

  assign req_n = ~(pend_q & en_q);

  AST_IRQ_DROP_NEEDS_ACK: assert property (@(posedge clk) disable iff (norm)
    $fell(pend_q) |-> $past(!ack_n)); // R5
  AST_IRQ_EVENT_WINS: assert property (@(posedge clk) disable iff (norm)
    event_i |=> pend_q); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (norm)
    !req_n |-> en_q); // R6
endmodule

// File: rtl/pcif_dma.sv
module pcif_dma (
  input  logic clk,
  input  logic norm,
  input  logic want,
  input  logic ack_n,
  output logic req_n
);
  logic req_q;
  logic hold_q;

  always_ff @(posedge clk) begin
    if (norm) begin
      req_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (req_q && !ack_n) begin
      req_q  <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      hold_q <= 1'b0;
      if (want && !hold_q) req_q <= 1'b1;
    end
  end

  assign req_n = ~req_q;

  AST_DMA_HELD: assert property (@(posedge clk) disable iff (norm)
    (req_q && ack_n) |=> req_q); // R7
  AST_DMA_GAP: assert property (@(posedge clk) disable iff (norm)
    $fell(req_q) |=> !req_q); // R7
endmodule

// File: rtl/pcif_ctrl.sv
module pcif_ctrl #(
  parameter int N_IRQ       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             init_cond,
  input  logic             cmd_stb_n,
  input  logic             wdata_stb_n,
  input  logic             stat_rd_n,
  input  logic             dev_busy,
  output logic             cmd_load,
  output logic             wdata_pulse,
  output logic             reject_flag,
  output logic             norm_out,
  input  logic [N_IRQ-1:0] irq_event,
  input  logic [N_IRQ-1:0] irq_ack_n,
  input  logic             irq_en_wr_n,
  input  logic [N_IRQ-1:0] irq_en_val,
  output logic [N_IRQ-1:0] irq_req_n,
  input  logic             dma_want,
  input  logic             dma_ack_n,
  output logic             dma_req_n
);
  import pcif_pkg::*;

  localparam int NSTB    = 3;
  localparam int IDX_CMD = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_STA = 2;

  logic            norm;
  logic [NSTB-1:0] stb_fall;
  logic            cmd_accept;
  logic            cmd_refuse;
  logic            load_q, wpulse_q, rej_q;

  pcif_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (init_cond),
    .q   (norm)
  );

  pcif_edge #(.W(NSTB)) u_edge (
    .clk   (clk),
    .stb_n ({stat_rd_n, wdata_stb_n, cmd_stb_n}),
    .fall  (stb_fall)
  );

  // Interlock: a command edge is accepted only when the work area is idle.
  assign cmd_accept = stb_fall[IDX_CMD] & ~dev_busy;
  assign cmd_refuse = stb_fall[IDX_CMD] &  dev_busy;

  always_ff @(posedge clk) begin
    if (norm) begin
      load_q   <= 1'b0;
      wpulse_q <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      load_q   <= cmd_accept;
      wpulse_q <= stb_fall[IDX_DAT];
      rej_q    <= sticky_next(rej_q, cmd_refuse, stb_fall[IDX_STA]);
    end
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    pcif_irq_chan u_chan (
      .clk     (clk),
      .norm    (norm),
      .event_i (irq_event[i]),
      .ack_n   (irq_ack_n[i]),
      .en_wr   (~irq_en_wr_n),
      .en_val  (irq_en_val[i]),
      .req_n   (irq_req_n[i])
    );
  end

  pcif_dma u_dma (
    .clk   (clk),
    .norm  (norm),
    .want  (dma_want),
    .ack_n (dma_ack_n),
    .req_n (dma_req_n)
  );

  assign cmd_load    = load_q;
  assign wdata_pulse = wpulse_q;
  assign reject_flag = rej_q;
  assign norm_out    = norm;

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (norm)
    cmd_load |=> !cmd_load); // R1
  AST_LOAD_NOT_BUSY: assert property (@(posedge clk) disable iff (norm)
    cmd_load |-> $past(!dev_busy)); // R2
  AST_REJ_AFTER_BUSY: assert property (@(posedge clk) disable iff (norm)
    $rose(reject_flag) |-> $past(dev_busy)); // R2
  AST_WDATA_ONE_CYCLE: assert property (@(posedge clk) disable iff (norm)
    wdata_pulse |=> !wdata_pulse); // R4
  AST_NORM_CLEARS: assert property (@(posedge clk)
    norm |=> (&irq_req_n && dma_req_n && !reject_flag && !cmd_load && !wdata_pulse)); // R8
  AST_NORM_FROM_INIT: assert property (@(posedge clk)
    $rose(norm) |-> $past(init_cond)); // R8
endmodule

// File: tb/pcif_ctrl_test.sv
module pcif_ctrl_test;
  logic       clk = 1'b0;
  logic       init_cond = 1'b1;
  logic       cmd_stb_n = 1'b1, wdata_stb_n = 1'b1, stat_rd_n = 1'b1, dev_busy = 1'b0;
  logic       cmd_load, wdata_pulse, reject_flag, norm_out;
  logic [1:0] irq_event = 2'b00, irq_ack_n = 2'b11, irq_en_val = 2'b00, irq_req_n;
  logic       irq_en_wr_n = 1'b1, dma_want = 1'b0, dma_ack_n = 1'b1, dma_req_n;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  pcif_ctrl uut (
    .clk(clk), .init_cond(init_cond), .cmd_stb_n(cmd_stb_n), .wdata_stb_n(wdata_stb_n),
    .stat_rd_n(stat_rd_n), .dev_busy(dev_busy), .cmd_load(cmd_load),
    .wdata_pulse(wdata_pulse), .reject_flag(reject_flag), .norm_out(norm_out),
    .irq_event(irq_event), .irq_ack_n(irq_ack_n), .irq_en_wr_n(irq_en_wr_n),
    .irq_en_val(irq_en_val), .irq_req_n(irq_req_n), .dma_want(dma_want),
    .dma_ack_n(dma_ack_n), .dma_req_n(dma_req_n)
  );

  // Vector: {cmd_n, dat_n, stat_n, busy, exp_load, exp_wpulse, exp_reject}
  localparam logic [6:0] VEC [13] = '{
    7'b1110_000,  // idle
    7'b0110_100,  // R1 accepted edge
    7'b0110_000,  // R1 held low, no repeat
    7'b1111_000,  // busy rises
    7'b0111_001,  // R2 refused, reject set
    7'b1111_001,  // R3 sticky
    7'b1011_011,  // R4 data edge while busy
    7'b1011_001,  // R4 held low
    7'b1100_000,  // R3 status read clears
    7'b1100_000,  // R3 held read
    7'b0110_100,  // R1 accept again
    7'b1010_010,  // R4 data edge
    7'b1110_000   // idle
  };

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(10 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(4);
    chk("R8 reset norm_out", {3'b0, norm_out}, 4'd1);
    chk("R8 reset outputs", {cmd_load, wdata_pulse, reject_flag, dma_req_n}, 4'b0001);
    chk("R8 reset irq_req_n", {2'b0, irq_req_n}, 4'b0011);
    init_cond = 1'b0;
    tick(1);
    chk("R8 sync delay stage 1", {3'b0, norm_out}, 4'd1);
    tick(1);
    chk("R8 sync released", {3'b0, norm_out}, 4'd0);

    // Strobes and interlock
    for (int v = 0; v < 13; v++) begin
      {cmd_stb_n, wdata_stb_n, stat_rd_n, dev_busy} = VEC[v][6:3];
      tick(1);
      chk($sformatf("R1/R2/R3/R4 vector %0d", v),
          {1'b0, cmd_load, wdata_pulse, reject_flag}, {1'b0, VEC[v][2:0]});
    end
    dev_busy = 1'b0;

    // Interrupts: enable channel 0 only
    irq_en_val = 2'b01; irq_en_wr_n = 1'b0; tick(1);
    irq_en_wr_n = 1'b1; irq_event = 2'b11; tick(1);
    irq_event = 2'b00;
    chk("R6 only enabled channel requests", {2'b0, irq_req_n}, 4'b0010);
    tick(2);
    chk("R5 request sticky", {2'b0, irq_req_n}, 4'b0010);
    irq_en_val = 2'b11; irq_en_wr_n = 1'b0; tick(1);
    irq_en_wr_n = 1'b1;
    chk("R6 pending channel 1 appears on enable", {2'b0, irq_req_n}, 4'b0000);
    irq_ack_n = 2'b10; tick(1);
    irq_ack_n = 2'b11;
    chk("R5 ack clears channel 0", {2'b0, irq_req_n}, 4'b0001);
    irq_ack_n = 2'b01; irq_event = 2'b10; tick(1);
    irq_ack_n = 2'b11; irq_event = 2'b00;
    chk("R5 set wins over ack", {2'b0, irq_req_n}, 4'b0001);
    irq_en_val = 2'b00; irq_en_wr_n = 1'b0; tick(1);
    irq_en_wr_n = 1'b1;
    chk("R6 disable hides pending", {2'b0, irq_req_n}, 4'b0011);
    irq_en_val = 2'b10; irq_en_wr_n = 1'b0; tick(1);
    irq_en_wr_n = 1'b1;
    chk("R6 re-enable shows pending", {2'b0, irq_req_n}, 4'b0001);

    // DMA
    dma_want = 1'b1; tick(1);
    chk("R7 request asserts", {3'b0, dma_req_n}, 4'd0);
    tick(3);
    chk("R7 held without grant", {3'b0, dma_req_n}, 4'd0);
    dma_ack_n = 1'b0; tick(1);
    dma_ack_n = 1'b1;
    chk("R7 drops on grant", {3'b0, dma_req_n}, 4'd1);
    tick(1);
    chk("R7 gap second sample", {3'b0, dma_req_n}, 4'd1);
    tick(1);
    chk("R7 reasserts after gap", {3'b0, dma_req_n}, 4'd0);

    // Normalize with state pending: reject set, irq1 active, dma active
    dev_busy = 1'b1; cmd_stb_n = 1'b0; tick(1);
    cmd_stb_n = 1'b1; dev_busy = 1'b0;
    chk("R2 reject before normalize", {3'b0, reject_flag}, 4'd1);
    init_cond = 1'b1; dma_want = 1'b0; tick(1);
    chk("R8 not yet normalized", {norm_out, dma_req_n, irq_req_n}, 4'b0001);
    tick(1);
    chk("R8 norm_out after two clocks", {3'b0, norm_out}, 4'd1);
    cmd_stb_n = 1'b0; wdata_stb_n = 1'b0; tick(1);
    chk("R8 flags cleared", {reject_flag, dma_req_n, irq_req_n}, 4'b0111);
    chk("R9 no strobes during normalize", {2'b0, cmd_load, wdata_pulse}, 4'd0);
    cmd_stb_n = 1'b1; wdata_stb_n = 1'b1; tick(1);
    init_cond = 1'b0; tick(3);
    chk("R8 normalize released", {3'b0, norm_out}, 4'd0);
    irq_event = 2'b11; tick(1);
    irq_event = 2'b00;
    chk("R9 enables stay cleared", {2'b0, irq_req_n}, 4'b0011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule